// File: doc/BRIEF.md
# Indirect PLL Configuration Window

This block sits behind one 32-bit host word and gives the host indirect access to a small bank of PLL configuration registers. The host selects a register by writing an index and a write-enable flag into byte lane 1 of the word. It then moves the register contents through byte lane 2. A complete update takes three writes: the index with write-enable set, the data byte, and the index again with write-enable clear. A read takes one index write with write-enable clear, followed by a read of lane 2.

The bank holds four values: the reference divider, the memory-clock feedback divider, the video-clock post-divider code and the video-clock feedback divider. All four go straight out to the clock logic. The post-divider code is also decoded into a one-hot divide ratio.

The write-enable flag is tracked by a small state machine with three states. LOCKED means write-enable is clear, and data writes are dropped. ARMED means write-enable is set and no data has been written yet. COMMITTED means write-enable is set and at least one data write has landed.

The transitions are as follows. An index write with the flag clear moves the machine from any state to LOCKED. An index write with the flag set moves it to ARMED. A data write accepted while the flag is in effect moves it to COMMITTED. When one host write carries both lanes and the flag set, the machine goes straight to COMMITTED. With no relevant write, the machine holds its state.

Top module: `pll_cfg_window`

## Requirements
- R1: After reset the index is 0 and write-enable is clear. The registers take their defaults: reference divider 36, memory feedback divider 120, post-divider code 2 and video feedback divider 96. Index 0 is unused, so `rdata` reads 0.
- R2: A write with `wr_strb[1]` set loads the index from `wdata[15:10]` and write-enable from `wdata[9]`. Bits 15:8 of `rdata` then read back {index, write-enable, 0}.
- R3: A write with `wr_strb[2]` set while write-enable is in effect stores `wdata[23:16]` into the indexed register at that clock edge, and the matching output follows. The register indices are: reference divider 0x02, memory feedback divider 0x04, video feedback divider 0x05 and post-divider code 0x06.
- R4: A lane-2 write while write-enable is clear changes no register.
- R5: `rdata[23:16]` always shows the register selected by the current index.
- R6: An index that maps to no register reads 0 on lane 2, and data writes to it change nothing.
- R7: The post-divider register keeps only data bits 1:0 and reads back zero-extended. Its ratio output is 1, 2, 4 or 8 for codes 0 to 3.
- R8: When lanes 1 and 2 are written in the same host write, the new index and write-enable apply to that write's data byte.
- R9: Lanes 0 and 3 always read 0, and writes to them have no effect.
- R10: With `wr_en` low, no strobe pattern changes any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host write qualifier |
| wr_strb | input | 4 | Per-byte write strobes |
| wdata | input | 32 | Host write data |
| rdata | output | 32 | Window read data |
| ref_div | output | 8 | Reference divider |
| mclk_fb_div | output | 8 | Memory-clock feedback divider |
| vclk_post_code | output | 2 | Video-clock post-divider code (log2 of the ratio) |
| vclk_post_ratio | output | 4 | Decoded one-hot post-divide ratio |
| vclk_fb_div | output | 8 | Video-clock feedback divider |

## Verification
The bench targets data writes that arrive with write-enable clear, which a faulty design would let corrupt a divider. It also targets single writes that carry both lanes, where a design using the stale index would write the wrong register.

Writes to unmapped indices are a further target: a wrong decode would alias them onto a real register. The bench also drives the post-divider register with wide data bytes, which would leak into the code and leave the ratio output no longer one-hot.

Writes on the dead lanes and strobes with `wr_en` low must leave the readback unchanged. A seeded random phase mixes all of these cases against a reference model.

// File: rtl/pllw_pkg.sv
package pllw_pkg;
    localparam int IDX_W  = 6;
    localparam int DATA_W = 8;
    localparam int NREG   = 4;
    localparam int POST_W = 2;

    typedef enum logic [1:0] {
        ST_LOCKED    = 2'd0,
        ST_ARMED     = 2'd1,
        ST_COMMITTED = 2'd2
    } wen_state_e;

    localparam logic [IDX_W-1:0] SEL_REF   = 6'h02;
    localparam logic [IDX_W-1:0] SEL_MFB   = 6'h04;
    localparam logic [IDX_W-1:0] SEL_VFB   = 6'h05;
    localparam logic [IDX_W-1:0] SEL_VPOST = 6'h06;

    // slot order: 0 ref, 1 memory fb, 2 post code, 3 video fb
    localparam logic [NREG-1:0][IDX_W-1:0] SEL_TAB = {SEL_VFB, SEL_VPOST, SEL_MFB, SEL_REF};
endpackage

// File: rtl/pllw_decode.sv
module pllw_decode
    import pllw_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output logic [NREG-1:0]  hit
);
    for (genvar i = 0; i < NREG; i++) begin : g_cmp
        assign hit[i] = (idx == SEL_TAB[i]);
    end
endmodule

// File: rtl/pllw_ctrl.sv
module pllw_ctrl
    import pllw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              lane1_stb,
    input  logic              lane2_stb,
    input  logic [7:1]        lane1_data,
    output logic [IDX_W-1:0]  idx_q,
    output logic [IDX_W-1:0]  eff_idx,
    output logic              we_q,
    output logic              commit,
    output wen_state_e        state_q
);
    wen_state_e state_d;
    logic       lane1_hit;
    logic       eff_we;

    assign lane1_hit = wr_en & lane1_stb;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOCKED;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (lane1_hit) idx_q <= lane1_data[7:2];
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOCKED: begin
                if (lane1_hit && lane1_data[1])
                    state_d = (wr_en && lane2_stb) ? ST_COMMITTED : ST_ARMED;
            end
            ST_ARMED, ST_COMMITTED: begin
                if (lane1_hit && !lane1_data[1])
                    state_d = ST_LOCKED;
                else if (wr_en && lane2_stb)
                    state_d = ST_COMMITTED;
                else if (lane1_hit)
                    state_d = ST_ARMED;
            end
            default: state_d = ST_LOCKED;
        endcase
    end

    // outputs
    always_comb begin
        we_q    = (state_q != ST_LOCKED);
        eff_we  = lane1_hit ? lane1_data[1] : we_q;
        eff_idx = lane1_hit ? lane1_data[7:2] : idx_q;
        commit  = wr_en & lane2_stb & eff_we;
    end
endmodule

// File: rtl/pllw_bank.sv
module pllw_bank
    import pllw_pkg::*;
#(
    parameter logic [NREG-1:0][DATA_W-1:0] RST_VALS = '0,
    parameter logic [NREG-1:0][DATA_W-1:0] MASKS    = '1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        commit,
    input  logic [NREG-1:0]             wr_hit,
    input  logic [DATA_W-1:0]           wr_byte,
    input  logic [NREG-1:0]             rd_hit,
    output logic [NREG-1:0][DATA_W-1:0] slot_q,
    output logic [DATA_W-1:0]           rd_byte
);
    for (genvar i = 0; i < NREG; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q[i] <= RST_VALS[i] & MASKS[i];
            else if (commit && wr_hit[i])
                slot_q[i] <= wr_byte & MASKS[i];
        end
    end

    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < NREG; i++)
            if (rd_hit[i]) rd_byte = rd_byte | slot_q[i];
    end
endmodule

// File: rtl/pll_cfg_window.sv
module pll_cfg_window
    import pllw_pkg::*;
#(
    parameter logic [7:0] REF_RST   = 8'd36,
    parameter logic [7:0] MFB_RST   = 8'd120,
    parameter logic [7:0] VPOST_RST = 8'd2,
    parameter logic [7:0] VFB_RST   = 8'd96
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [3:0]  wr_strb,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic [7:0]  ref_div,
    output logic [7:0]  mclk_fb_div,
    output logic [1:0]  vclk_post_code,
    output logic [3:0]  vclk_post_ratio,
    output logic [7:0]  vclk_fb_div
);
    localparam int RATIO_W = 1 << POST_W;
    localparam logic [NREG-1:0][DATA_W-1:0] RST_VALS = {VFB_RST, VPOST_RST, MFB_RST, REF_RST};
    localparam logic [NREG-1:0][DATA_W-1:0] MASKS =
        {8'hFF, 8'((1 << POST_W) - 1), 8'hFF, 8'hFF};

    logic [IDX_W-1:0]             idx_q;
    logic [IDX_W-1:0]             eff_idx;
    logic                         we_q;
    logic                         commit;
    wen_state_e                   ctl_state;
    logic [NREG-1:0]              wr_hit;
    logic [NREG-1:0]              rd_hit;
    logic [NREG-1:0][DATA_W-1:0]  slot_q;
    logic [DATA_W-1:0]            rd_byte;
    logic                         unused_lanes;

    assign unused_lanes = ^{wdata[31:24], wdata[8:0], wr_strb[3], wr_strb[0], slot_q[2][7:2]};

    pllw_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .lane1_stb  (wr_strb[1]),
        .lane2_stb  (wr_strb[2]),
        .lane1_data (wdata[15:9]),
        .idx_q      (idx_q),
        .eff_idx    (eff_idx),
        .we_q       (we_q),
        .commit     (commit),
        .state_q    (ctl_state)
    );

    pllw_decode u_wdec (.idx(eff_idx), .hit(wr_hit));
    pllw_decode u_rdec (.idx(idx_q),   .hit(rd_hit));

    pllw_bank #(.RST_VALS(RST_VALS), .MASKS(MASKS)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .commit  (commit),
        .wr_hit  (wr_hit),
        .wr_byte (wdata[23:16]),
        .rd_hit  (rd_hit),
        .slot_q  (slot_q),
        .rd_byte (rd_byte)
    );

    assign rdata           = {8'h00, rd_byte, idx_q, we_q, 1'b0, 8'h00};
    assign ref_div         = slot_q[0];
    assign mclk_fb_div     = slot_q[1];
    assign vclk_post_code  = slot_q[2][POST_W-1:0];
    assign vclk_post_ratio = RATIO_W'(1) << slot_q[2][POST_W-1:0];
    assign vclk_fb_div     = slot_q[3];
endmodule

// File: rtl/pllw_chk.sv
module pllw_chk
    import pllw_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [3:0]  wr_strb,
    input logic [31:0] wdata,
    input logic [31:0] rdata,
    input logic [7:0]  ref_div,
    input logic [7:0]  mclk_fb_div,
    input logic [1:0]  vclk_post_code,
    input logic [3:0]  vclk_post_ratio,
    input logic [7:0]  vclk_fb_div,
    input logic [1:0]  fsm_state
);
    assert_idx_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_strb[1]) |=> (rdata[15:8] == {$past(wdata[15:9]), 1'b0}));

    assert_write_hits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_strb[2] && !wr_strb[1] && rdata[9] && rdata[15:10] == SEL_REF)
        |=> (ref_div == $past(wdata[23:16])));

    assert_commit_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_strb[2] && !wr_strb[1] && rdata[9]) |=> (fsm_state == ST_COMMITTED));

    assert_drop_locked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_strb[2] && !wr_strb[1] && !rdata[9])
        |=> $stable({ref_div, mclk_fb_div, vclk_post_code, vclk_fb_div}));

    assert_ratio_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(vclk_post_ratio) == 1);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(rdata) && $stable({ref_div, mclk_fb_div, vclk_post_code, vclk_fb_div})));
endmodule

bind pll_cfg_window pllw_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .wr_en           (wr_en),
    .wr_strb         (wr_strb),
    .wdata           (wdata),
    .rdata           (rdata),
    .ref_div         (ref_div),
    .mclk_fb_div     (mclk_fb_div),
    .vclk_post_code  (vclk_post_code),
    .vclk_post_ratio (vclk_post_ratio),
    .vclk_fb_div     (vclk_fb_div),
    .fsm_state       (ctl_state)
);

// File: tb/tb_pll_cfg_window.sv
module tb_pll_cfg_window;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_strb = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  ref_div, mclk_fb_div, vclk_fb_div;
    logic [1:0]  vclk_post_code;
    logic [3:0]  vclk_post_ratio;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [5:0] m_idx;
    logic       m_we;
    logic [7:0] m_ref, m_mfb, m_vpost, m_vfb;

    always #5 clk = ~clk;

    pll_cfg_window dut (.*);

    function automatic logic [7:0] model_rd(input logic [5:0] i);
        case (i)
            6'h02:   return m_ref;
            6'h04:   return m_mfb;
            6'h05:   return m_vfb;
            6'h06:   return m_vpost;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [31:0] exp_rdata();
        return {8'h00, model_rd(m_idx), m_idx, m_we, 1'b0, 8'h00};
    endfunction

    function automatic logic [29:0] exp_outs();
        return {m_ref, m_mfb, m_vpost[1:0], 4'(1) << m_vpost[1:0], m_vfb};
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check(tag, rdata, exp_rdata());
        check(tag, {2'b00, ref_div, mclk_fb_div, vclk_post_code, vclk_post_ratio, vclk_fb_div},
              {2'b00, exp_outs()});
    endtask

    task automatic model_reset();
        m_idx = '0; m_we = 1'b0;
        m_ref = 8'd36; m_mfb = 8'd120; m_vpost = 8'd2; m_vfb = 8'd96;
    endtask

    task automatic model_write(input logic en, input logic [3:0] s, input logic [31:0] d);
        if (en && s[1]) begin
            m_idx = d[15:10];
            m_we  = d[9];
        end
        if (en && s[2] && m_we) begin
            case (m_idx)
                6'h02: m_ref   = d[23:16];
                6'h04: m_mfb   = d[23:16];
                6'h05: m_vfb   = d[23:16];
                6'h06: m_vpost = {6'd0, d[17:16]};
                default: ;
            endcase
        end
    endtask

    // drive on falling edge, let the rising edge act, check on the next falling edge
    task automatic step(input string tag, input logic en, input logic [3:0] s, input logic [31:0] d);
        wr_en = en; wr_strb = s; wdata = d;
        @(posedge clk);
        model_write(en, s, d);
        @(negedge clk);
        wr_en = 1'b0; wr_strb = '0;
        check_all(tag);
    endtask

    function automatic logic [31:0] idxw(input logic [5:0] i, input logic we);
        return {16'h0000, i, we, 1'b0, 8'h00};
    endfunction

    function automatic logic [31:0] datw(input logic [7:0] v);
        return {8'h00, v, 16'h0000};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R2 / R5: select memory fb divider for reading
        step("R2", 1'b1, 4'b0010, idxw(6'h04, 1'b0));
        check("R5", {24'h0, rdata[23:16]}, 32'd120);
        // R4: data write while locked is dropped
        step("R4", 1'b1, 4'b0100, datw(8'h5A));
        // R3: full three-write update
        step("R3", 1'b1, 4'b0010, idxw(6'h04, 1'b1));
        step("R3", 1'b1, 4'b0100, datw(8'h55));
        step("R3", 1'b1, 4'b0010, idxw(6'h04, 1'b0));
        check("R3", {24'h0, mclk_fb_div}, 32'h55);
        step("R4", 1'b1, 4'b0100, datw(8'hEE));
        // R7: post code only keeps two bits
        step("R7", 1'b1, 4'b0010, idxw(6'h06, 1'b1));
        for (int c = 0; c < 4; c++) begin
            step("R7", 1'b1, 4'b0100, datw(8'hFC | 8'(c)));
            check("R7", {28'h0, vclk_post_ratio}, 32'd1 << c);
        end
        // R6: unmapped index
        step("R6", 1'b1, 4'b0010, idxw(6'h3F, 1'b1));
        step("R6", 1'b1, 4'b0100, datw(8'hAA));
        step("R6", 1'b1, 4'b0010, idxw(6'h03, 1'b1));
        step("R6", 1'b1, 4'b0100, datw(8'h11));
        // R8: both lanes in one write
        step("R8", 1'b1, 4'b0110, {8'h00, 8'h77, 6'h05, 1'b1, 1'b0, 8'h00});
        check("R8", {24'h0, vclk_fb_div}, 32'h77);
        step("R8", 1'b1, 4'b0110, {8'h00, 8'h99, 6'h02, 1'b0, 1'b0, 8'h00});
        // R9: dead lanes
        step("R9", 1'b1, 4'b1001, 32'hFFFF_FFFF);
        step("R9", 1'b1, 4'b1000, 32'hA5A5_A5A5);
        // R10: wr_en low with all strobes
        step("R10", 1'b0, 4'b1111, {8'hFF, 8'h33, 6'h02, 1'b1, 1'b0, 8'hFF});
        step("R10", 1'b1, 4'b0010, idxw(6'h02, 1'b1));
        step("R10", 1'b0, 4'b0100, datw(8'h44));

        // seeded random phase
        seed = $urandom(32'd1234);
        for (int n = 0; n < 800; n++) begin
            logic [5:0]  ri;
            logic [31:0] rw;
            case ($urandom_range(0, 5))
                0: ri = 6'h02;
                1: ri = 6'h04;
                2: ri = 6'h05;
                3: ri = 6'h06;
                4: ri = 6'h00;
                default: ri = 6'($urandom);
            endcase
            rw = $urandom;
            rw[15:10] = ri;
            step("R5", ($urandom_range(0, 7) != 0), 4'($urandom), rw);
        end

        // reset again mid-run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
        check_all("R1");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule